// File: doc/BRIEF.md
# Exception-Bit Conditional Select Unit

This unit is the execution datapath for a family of four conditional select operations. Each operation writes one of two candidate values to a 64-bit destination. The choice depends on one bit of a 16-bit extended exception field. Each candidate comes either from a general-purpose register read port or from a 5-bit signed immediate carried in the instruction. A 2-bit form code names which of the four source combinations is in use.

The tested bit is named by a 4-bit index. Element 0 of the exception input is architectural bit 32, so the index reaches architectural bits 32 through 47. An optional record flag asks for a 3-bit condition code. This code comes from the signed comparison of the result with zero.

The selection logic is combinational. The result, its write enable and the condition update are registered once, which gives a fixed latency of one cycle. Register storage, fetch and the logic that sets the exception bits sit outside this unit.

Top module: `exsel_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operation, `res_we`, `res_data`, `cr_we` and `cr_out` are all zero.
- R2: `form[1]` sets the source of the first candidate: 1 means `src_a`, 0 means the immediate `imm_a`. `form[0]` sets the source of the second candidate: 1 means `src_b`, 0 means `imm_b`. So 00 is imm/imm, 01 is imm/reg, 10 is reg/imm and 11 is reg/reg.
- R3: Each immediate is a 5-bit two's complement value from -16 to +15. It is sign-extended to 64 bits, so an immediate of 0 gives all zeros and -1 gives all ones.
- R4: The tested bit is `xfield[xidx]`. Index 0 selects element 0 (architectural bit 32) and index 15 selects element 15 (architectural bit 47).
- R5: When the tested bit is 1, the first candidate is written. When it is 0, the second candidate is written.
- R6: An operation accepted with `op_valid` high at a clock edge gives `res_we` high and its result on `res_data` after that same edge, which is one cycle of latency. Back-to-back operations give back-to-back results.
- R7: An accepted operation with `rec_en` high raises `cr_we` in the result cycle. `cr_out` then holds {less, greater, equal} for the signed comparison of the result with zero (bit 2 less, bit 1 greater, bit 0 equal), with exactly one bit set.
- R8: An accepted operation with `rec_en` low leaves `cr_we` low and `cr_out` unchanged.
- R9: In a cycle with `op_valid` low, `res_we` and `cr_we` go low and `res_data` and `cr_out` keep their values, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| form | input | 2 | Source form: bit 1 first candidate, bit 0 second candidate (1 = register) |
| src_a | input | 64 | Register value for the first candidate |
| src_b | input | 64 | Register value for the second candidate |
| imm_a | input | 5 | Signed immediate for the first candidate |
| imm_b | input | 5 | Signed immediate for the second candidate |
| xidx | input | 4 | Index of the tested exception bit (0 = architectural bit 32) |
| xfield | input | 16 | Extended exception bits, element 0 = architectural bit 32 |
| rec_en | input | 1 | Record flag: update the condition code |
| res_we | output | 1 | Destination write enable, one cycle after acceptance |
| res_data | output | 64 | Selected and extended result |
| cr_we | output | 1 | Condition code write enable |
| cr_out | output | 3 | Condition code {less, greater, equal} |

## Verification
The checker assumes that the inputs are stable and known at each rising edge whenever `op_valid` is high. It also assumes that `form`, `xidx` and `xfield` carry meaningful values only in those cycles. No assumption is made about idle cycles, so the idle-cycle checks in the checker hold for any input values. The stimulus drives every input at the falling edge, away from the sampling edge. In idle cycles it deliberately puts random data, random forms and a raised record flag on the inputs, so the hold behaviour is tested against inputs that would otherwise change the outputs. Operands come from both fixed corner values (-16, +15, 0, -1, zero and negative registers, indices 0 and 15) and random values, all inside their legal widths.

// File: rtl/exsel_pkg.sv
package exsel_pkg;

   // Source form of the two candidates; bit 1 = first, bit 0 = second, 1 = register
   typedef enum logic [1:0] {
      FORM_II = 2'b00,
      FORM_IR = 2'b01,
      FORM_RI = 2'b10,
      FORM_RR = 2'b11
   } form_e;

   // Condition code bit positions
   localparam int CR_LT = 2;
   localparam int CR_GT = 1;
   localparam int CR_EQ = 0;
   localparam int CR_W  = 3;

   function automatic logic cand_is_reg(input form_e f, input int cand);
      return (cand == 0) ? f[1] : f[0];
   endfunction

endpackage

// File: rtl/exsel_opnd.sv
module exsel_opnd #(
   parameter int DATA_W     = 64,
   parameter int IMM_W      = 5,
   parameter bit IMM_SIGNED = 1'b1
) (
   input  logic              use_reg,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] opnd
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   if (IMM_W < 2 || IMM_W >= DATA_W) begin : g_bad_imm_w
      $error("exsel_opnd: IMM_W must be between 2 and DATA_W-1");
   end

   if (IMM_SIGNED) begin : g_sext
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
   end else begin : g_zext
      assign imm_ext = {{EXT_W{1'b0}}, imm_val};
   end

   assign opnd = use_reg ? reg_val : imm_ext;

endmodule

// File: rtl/exsel_bitpick.sv
module exsel_bitpick #(
   parameter int XFLD_W = 16,
   localparam int IDX_W = $clog2(XFLD_W)
) (
   input  logic [XFLD_W-1:0] xfield,
   input  logic [IDX_W-1:0]  xidx,
   output logic              xbit
);
   if (XFLD_W < 2 || (1 << IDX_W) != XFLD_W) begin : g_bad_xfld_w
      $error("exsel_bitpick: XFLD_W must be a power of two, at least 2");
   end

   // One-hot decode of the index, then an AND-OR reduction
   logic [XFLD_W-1:0] hit;

   for (genvar k = 0; k < XFLD_W; k++) begin : g_hit
      assign hit[k] = (xidx == IDX_W'(k)) & xfield[k];
   end

   assign xbit = |hit;

endmodule

// File: rtl/exsel_cmp.sv
module exsel_cmp
   import exsel_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] value,
   output logic [CR_W-1:0]   cr
);
   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[DATA_W-1];

   always_comb begin
      cr        = '0;
      cr[CR_LT] = is_neg;
      cr[CR_GT] = !is_neg && !is_zero;
      cr[CR_EQ] = is_zero;
   end

endmodule

// File: rtl/exsel_unit.sv
module exsel_unit
   import exsel_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int IMM_W      = 5,
   parameter int XFLD_W     = 16,
   parameter bit IMM_SIGNED = 1'b1,
   localparam int IDX_W     = $clog2(XFLD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        form,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm_a,
   input  logic [IMM_W-1:0]  imm_b,
   input  logic [IDX_W-1:0]  xidx,
   input  logic [XFLD_W-1:0] xfield,
   input  logic              rec_en,
   output logic              res_we,
   output logic [DATA_W-1:0] res_data,
   output logic              cr_we,
   output logic [CR_W-1:0]   cr_out
);
   localparam int NCAND = 2;

   if (DATA_W < 8) begin : g_bad_data_w
      $error("exsel_unit: DATA_W must be at least 8");
   end

   form_e                    form_q;
   logic [DATA_W-1:0]        reg_in [NCAND];
   logic [IMM_W-1:0]         imm_in [NCAND];
   logic [DATA_W-1:0]        cand   [NCAND];
   logic                     xbit;
   logic [DATA_W-1:0]        sel_res;
   logic [CR_W-1:0]          sel_cr;

   assign form_q    = form_e'(form);
   assign reg_in[0] = src_a;
   assign reg_in[1] = src_b;
   assign imm_in[0] = imm_a;
   assign imm_in[1] = imm_b;

   // Candidate operand formation, one per source slot
   for (genvar c = 0; c < NCAND; c++) begin : g_cand
      exsel_opnd #(
         .DATA_W    (DATA_W),
         .IMM_W     (IMM_W),
         .IMM_SIGNED(IMM_SIGNED)
      ) i_opnd (
         .use_reg(cand_is_reg(form_q, c)),
         .reg_val(reg_in[c]),
         .imm_val(imm_in[c]),
         .opnd   (cand[c])
      );
   end

   exsel_bitpick #(
      .XFLD_W(XFLD_W)
   ) i_bitpick (
      .xfield(xfield),
      .xidx  (xidx),
      .xbit  (xbit)
   );

   assign sel_res = xbit ? cand[0] : cand[1];

   exsel_cmp #(
      .DATA_W(DATA_W)
   ) i_cmp (
      .value(sel_res),
      .cr   (sel_cr)
   );

   // Single output stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_we   <= 1'b0;
         res_data <= '0;
         cr_we    <= 1'b0;
         cr_out   <= '0;
      end else begin
         res_we <= op_valid;
         cr_we  <= op_valid && rec_en;
         if (op_valid) begin
            res_data <= sel_res;
         end
         if (op_valid && rec_en) begin
            cr_out <= sel_cr;
         end
      end
   end

endmodule

// File: rtl/exsel_unit_chk.sv
module exsel_unit_chk #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 5,
   parameter int XFLD_W = 16,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        form,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [IDX_W-1:0]  xidx,
   input logic [XFLD_W-1:0] xfield,
   input logic              rec_en,
   input logic              res_we,
   input logic [DATA_W-1:0] res_data,
   input logic              cr_we,
   input logic [2:0]        cr_out
);
   localparam int HI_W = DATA_W - IMM_W + 1;

   AST_WE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_we); // R6
   AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_we && !cr_we); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(res_data) && $stable(cr_out)); // R9
   AST_NOREC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !rec_en |=> !cr_we && $stable(cr_out)); // R8
   AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> $countones(cr_out) == 1); // R7
   AST_CR_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> cr_out[0] == (res_data == '0)); // R7
   AST_CR_LT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> cr_out[2] == res_data[DATA_W-1]); // R7
   AST_RR_PICK_A: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && form == 2'b11 && xfield[xidx] |=> res_data == $past(src_a)); // R5
   AST_RR_PICK_B: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && form == 2'b11 && !xfield[xidx] |=> res_data == $past(src_b)); // R5
   AST_II_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && form == 2'b00 |=>
         (res_data[DATA_W-1:IMM_W-1] == '0) || (res_data[DATA_W-1:IMM_W-1] == {HI_W{1'b1}})); // R3

endmodule

bind exsel_unit exsel_unit_chk #(
   .DATA_W(DATA_W),
   .IMM_W (IMM_W),
   .XFLD_W(XFLD_W),
   .IDX_W (IDX_W)
) i_exsel_unit_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_valid(op_valid),
   .form    (form),
   .src_a   (src_a),
   .src_b   (src_b),
   .xidx    (xidx),
   .xfield  (xfield),
   .rec_en  (rec_en),
   .res_we  (res_we),
   .res_data(res_data),
   .cr_we   (cr_we),
   .cr_out  (cr_out)
);

// File: tb/test_exsel_unit.sv
module test_exsel_unit;

   typedef struct {
      logic [63:0] data;
      logic        rec;
      logic [2:0]  cr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  form = 2'b00;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [4:0]  imm_a = '0;
   logic [4:0]  imm_b = '0;
   logic [3:0]  xidx = '0;
   logic [15:0] xfield = '0;
   logic        rec_en = 1'b0;
   logic        res_we;
   logic [63:0] res_data;
   logic        cr_we;
   logic [2:0]  cr_out;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   mon_on   = 1'b0;
   bit   done     = 1'b0;
   exp_t sb[$];
   logic [63:0] last_data = '0;
   logic [2:0]  last_cr   = '0;

   always #5 clk = ~clk;

   exsel_unit i_exsel_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_valid(op_valid),
      .form    (form),
      .src_a   (src_a),
      .src_b   (src_b),
      .imm_a   (imm_a),
      .imm_b   (imm_b),
      .xidx    (xidx),
      .xfield  (xfield),
      .rec_en  (rec_en),
      .res_we  (res_we),
      .res_data(res_data),
      .cr_we   (cr_we),
      .cr_out  (cr_out)
   );

   function automatic logic [63:0] sext5(input logic [4:0] v);
      return {{59{v[4]}}, v};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: presents one operation and queues its expected outcome
   task automatic drive(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] ia, input logic [4:0] ib, input logic [3:0] idx,
                        input logic [15:0] xf, input logic rec, input string tag);
      exp_t        e;
      logic [63:0] c1, c2;
      @(negedge clk);
      op_valid = 1'b1; form = f; src_a = a; src_b = b;
      imm_a = ia; imm_b = ib; xidx = idx; xfield = xf; rec_en = rec;
      c1 = f[1] ? a : sext5(ia);          // R2
      c2 = f[0] ? b : sext5(ib);
      e.data = xf[idx] ? c1 : c2;         // R4 R5
      e.rec  = rec;
      e.cr   = $signed(e.data) < 0 ? 3'b100 : (e.data == 0 ? 3'b001 : 3'b010);
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // Idle cycles with noisy inputs that must be ignored (R9)
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_valid = 1'b0; rec_en = 1'b1; form = 2'($urandom);
         src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
         imm_a = 5'($urandom); imm_b = 5'($urandom);
         xidx = 4'($urandom); xfield = 16'($urandom);
      end
   endtask

   // Monitor: compares outputs against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (res_we) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R6 unexpected result", {63'd0, res_we}, 64'd0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(res_data === e.data, e.tag, res_data, e.data);
                  last_data = e.data;
                  if (e.rec) begin
                     check(cr_we === 1'b1 && cr_out === e.cr, "R7 condition code",
                           {60'd0, cr_we, cr_out}, {61'd1, e.cr});
                     last_cr = e.cr;
                  end else begin
                     check(cr_we === 1'b0 && cr_out === last_cr, "R8 no record",
                           {60'd0, cr_we, cr_out}, {61'd0, last_cr});
                  end
               end
            end else begin
               check(sb.size() == 0, "R6 result missing", 64'(sb.size()), 64'd0);
               check(cr_we === 1'b0 && res_data === last_data && cr_out === last_cr,
                     "R9 idle hold", res_data, last_data);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(res_we === 1'b0 && cr_we === 1'b0, "R1 reset enables",
            {62'd0, res_we, cr_we}, 64'd0);
      check(res_data === '0 && cr_out === '0, "R1 reset data", res_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_we === 1'b0 && res_data === '0 && cr_out === '0, "R1 after release",
            res_data, 64'd0);
      mon_on = 1'b1;

      // Forms, each with the tested bit both set and clear
      drive(2'b00, 64'h0, 64'h0, 5'd15, 5'd16, 4'd0, 16'h0001, 1'b1, "R2 R3 imm/imm +15");
      drive(2'b00, 64'h0, 64'h0, 5'd15, 5'd16, 4'd0, 16'hFFFE, 1'b1, "R2 R3 imm/imm -16");
      drive(2'b01, 64'h0, 64'hDEAD_BEEF_0123_4567, 5'd0, 5'd3, 4'd9, 16'h0200, 1'b1,
            "R2 R3 imm/reg zero imm");
      drive(2'b01, 64'h0, 64'hDEAD_BEEF_0123_4567, 5'd0, 5'd3, 4'd9, 16'hFDFF, 1'b0,
            "R2 imm/reg register");
      idle(2);
      drive(2'b10, 64'h8000_0000_0000_0000, 64'h0, 5'd7, 5'd31, 4'd15, 16'h8000, 1'b1,
            "R2 R4 reg/imm idx 15");
      drive(2'b10, 64'h8000_0000_0000_0000, 64'h0, 5'd7, 5'd31, 4'd15, 16'h7FFF, 1'b1,
            "R2 R3 R4 reg/imm all ones");
      drive(2'b11, 64'h1111, 64'h2222, 5'd0, 5'd0, 4'd5, 16'h0020, 1'b0,
            "R2 R5 reg/reg set");
      drive(2'b11, 64'h1111, 64'h2222, 5'd0, 5'd0, 4'd5, 16'hFFDF, 1'b0,
            "R2 R5 reg/reg clear");
      idle(3);
      // Walk the index over every bit with a single set bit
      for (int k = 0; k < 16; k++) begin
         drive(2'b11, 64'(k + 100), 64'h0, 5'd0, 5'd0, 4'(k), 16'(1 << k), 1'b1,
               "R4 index walk");
      end
      drive(2'b00, 64'h0, 64'h0, 5'd0, 5'd0, 4'd3, 16'h0008, 1'b1, "R3 R7 zero result");
      drive(2'b00, 64'h0, 64'h0, 5'd1, 5'd0, 4'd3, 16'h0008, 1'b0, "R8 no record");
      idle(2);
      // Random mix, back-to-back and with gaps
      for (int n = 0; n < 300; n++) begin
         drive(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom),
               5'($urandom), 4'($urandom), 16'($urandom), 1'($urandom), "R5 R6 random");
         if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      end
      idle(3);
      mon_on = 1'b0;
      done   = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule